// File: doc/BRIEF.md
# Four-Channel Dual-Update PWM Generator

This block drives four pulse-width modulated outputs from one shared period counter. The counter either ramps up and wraps, giving edge-aligned pulses, or ramps up and then back down, giving center-aligned pulses. Each channel compares the counter against its own duty value. In paired operation, the two outputs of each pair are complements of one another. In independent operation, each output follows its own duty value.

Software reaches the block through a single-cycle register write port. Every duty, period and mode write lands in a shadow register. The running waveform only picks up the new values at reload points, so a pulse in flight is never cut short. In center-aligned operation, the duties can optionally be reloaded a second time at the counter peak. The falling half of a period can then use a different value from the rising half, which produces asymmetric pulses. The enable bit is the only register that acts immediately.

Top module: `quad_pwm_gen`

## Requirements
- R1: While reset is high and after it falls, all four outputs are low and the generator stays disabled until the enable bit is written.
- R2: A write with wr_en high lands at that clock edge. Address 0 to 3 selects the duty of channel 0 to 3. Address 4 is the period. Address 5 is the mode: bit0 selects center-aligned, bit1 selects double update, bit2 selects paired. Address 6 bit0 is the enable.
- R3: In edge-aligned mode the count runs 0, 1, ..., P-1 and wraps, so a period lasts P cycles. Channel i is high while the count is below its duty. The first enabled cycle, one cycle after the enable write, has count 0.
- R4: In center-aligned mode the count runs 0 up to P-1, then P down to 1, so a period lasts 2P cycles. A channel is high in the rising half when the count is at least P-D. It is high in the falling half when the count exceeds P-D. The pulse therefore lasts 2D cycles and is centered on the peak.
- R5: A duty of 0 keeps the output low for the whole period. A duty equal to or above the period keeps it high.
- R6: Duty, period and mode writes made during a period do not change that period. They take effect from the first cycle of the next period. With double update off, this is the only reload point.
- R7: In center-aligned mode with double update on, the duties are also reloaded as the count reaches the peak, so the falling half uses the duties written during the rising half. Period and mode still change only at the period end.
- R8: In paired mode, output 1 is the inverse of output 0 and output 3 is the inverse of output 2. Outputs 0 and 2 follow duties 0 and 2, and duties 1 and 3 have no effect.
- R9: In independent mode, each of the four outputs follows only its own duty value.
- R10: Clearing the enable drives all outputs low from the next cycle and holds the count at 0. On re-enable, the first period uses the shadow values that stood when the enable was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write value |
| pwm_out | output | 4 | PWM outputs, bit i is channel i |

## Verification
A software write to a duty register can land on the very clock edge where the counter turns at its peak and the midpoint reload copies the shadows into the active registers. The bench provokes this by writing channel 2 at the last rising-half cycle of a center-aligned period, in both single and double update. It expects the falling half to keep the old duty, because the reload copies the value that stood before the write. The new duty must appear only from the next period end. The same scenario also checks an earlier write that the midpoint reload must pick up, so both sides of that edge are judged against an independently computed waveform.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;

    // Mode register layout, bit0 = center, bit1 = double update, bit2 = paired
    typedef struct packed {
        logic paired;
        logic dbl;
        logic center;
    } pwm_mode_t;

    localparam int MODE_W = 3;

    // Level of one channel for a given count position
    function automatic logic pwm_level(input logic [31:0] cnt,
                                       input logic [31:0] per,
                                       input logic [31:0] duty,
                                       input logic        center,
                                       input logic        down);
        logic lvl;
        if (duty == 32'd0)
            lvl = 1'b0;
        else if (duty >= per)
            lvl = 1'b1;
        else if (!center)
            lvl = (cnt < duty);
        else if (!down)
            lvl = (cnt >= per - duty);
        else
            lvl = (cnt > per - duty);
        return lvl;
    endfunction

endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
    import quad_pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 4,
    parameter int AW    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [NCH-1:0][CNT_W-1:0]  shd_duty,
    output logic [CNT_W-1:0]           shd_period,
    output pwm_mode_t                  shd_mode,
    output logic                       run_en
);

    localparam int ADDR_PERIOD = NCH;
    localparam int ADDR_MODE   = NCH + 1;
    localparam int ADDR_EN     = NCH + 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd_duty   <= '0;
            shd_period <= '0;
            shd_mode   <= '0;
            run_en     <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(i))
                    shd_duty[i] <= wr_data;
            end
            if (wr_addr == AW'(ADDR_PERIOD))
                shd_period <= wr_data;
            if (wr_addr == AW'(ADDR_MODE))
                shd_mode <= pwm_mode_t'(wr_data[MODE_W-1:0]);
            if (wr_addr == AW'(ADDR_EN))
                run_en <= wr_data[0];
        end
    end

endmodule

// File: rtl/quad_pwm_timebase.sv
module quad_pwm_timebase
    import quad_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CNT_W-1:0] shd_period,
    input  pwm_mode_t        shd_mode,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic [CNT_W-1:0] act_period,
    output pwm_mode_t        act_mode,
    output logic             duty_load
);

    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_down;
    logic             end_evt;
    logic             mid_evt;

    always_comb begin
        nxt_cnt  = cnt;
        nxt_down = down;
        end_evt  = 1'b0;
        mid_evt  = 1'b0;
        if (!run_en) begin
            nxt_cnt  = '0;
            nxt_down = 1'b0;
        end else if (!act_mode.center) begin
            if (cnt >= act_period - CNT_W'(1)) begin
                nxt_cnt = '0;
                end_evt = 1'b1;
            end else begin
                nxt_cnt = cnt + CNT_W'(1);
            end
        end else if (!down) begin
            if (cnt >= act_period - CNT_W'(1)) begin
                nxt_cnt  = act_period;
                nxt_down = 1'b1;
                mid_evt  = 1'b1;
            end else begin
                nxt_cnt = cnt + CNT_W'(1);
            end
        end else begin
            if (cnt <= CNT_W'(1)) begin
                nxt_cnt  = '0;
                nxt_down = 1'b0;
                end_evt  = 1'b1;
            end else begin
                nxt_cnt = cnt - CNT_W'(1);
            end
        end
    end

    // Duties follow the shadows while stopped, at every period end,
    // and at the peak when double update is active.
    assign duty_load = !run_en || end_evt || (mid_evt && act_mode.dbl);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            down       <= 1'b0;
            act_period <= CNT_W'(1);
            act_mode   <= '0;
        end else begin
            cnt  <= nxt_cnt;
            down <= nxt_down;
            if (!run_en || end_evt) begin
                act_period <= (shd_period == '0) ? CNT_W'(1) : shd_period;
                act_mode   <= shd_mode;
            end
        end
    end

    a_r3_edge_bound: assert property (@(posedge clk) disable iff (rst)
        (run_en && !act_mode.center) |-> (cnt < act_period));

    a_r4_center_bound: assert property (@(posedge clk) disable iff (rst)
        (run_en && act_mode.center) |-> (cnt <= act_period));

    a_r4_turn_at_peak: assert property (@(posedge clk) disable iff (rst)
        $rose(down) |-> (cnt == act_period));

    a_r10_hold_zero: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (cnt == '0 && !down));

endmodule

// File: rtl/quad_pwm_channel.sv
module quad_pwm_channel
    import quad_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             duty_load,
    input  logic [CNT_W-1:0] shd_duty,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_period,
    input  logic             center,
    input  logic             down,
    output logic             level
);

    logic [CNT_W-1:0] act_duty;

    always_ff @(posedge clk) begin
        if (rst)
            act_duty <= '0;
        else if (duty_load)
            act_duty <= shd_duty;
    end

    assign level = pwm_level(32'(cnt), 32'(act_period), 32'(act_duty), center, down);

    a_r6_duty_hold: assert property (@(posedge clk) disable iff (rst)
        !duty_load |=> $stable(act_duty));

    a_r5_zero_low: assert property (@(posedge clk) disable iff (rst)
        (act_duty == '0) |-> !level);

    a_r5_full_high: assert property (@(posedge clk) disable iff (rst)
        (act_duty != '0 && act_duty >= act_period) |-> level);

endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen
    import quad_pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 4,
    parameter int AW    = $clog2(NCH + 3)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [NCH-1:0]   pwm_out
);

    localparam int NPAIR = NCH / 2;

    logic [NCH-1:0][CNT_W-1:0] shd_duty;
    logic [CNT_W-1:0]          shd_period;
    pwm_mode_t                 shd_mode;
    logic                      run_en;
    logic [CNT_W-1:0]          cnt;
    logic                      down;
    logic [CNT_W-1:0]          act_period;
    pwm_mode_t                 act_mode;
    logic                      duty_load;
    logic [NCH-1:0]            level;

    quad_pwm_regs #(.CNT_W(CNT_W), .NCH(NCH), .AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .shd_duty   (shd_duty),
        .shd_period (shd_period),
        .shd_mode   (shd_mode),
        .run_en     (run_en)
    );

    quad_pwm_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .shd_period (shd_period),
        .shd_mode   (shd_mode),
        .cnt        (cnt),
        .down       (down),
        .act_period (act_period),
        .act_mode   (act_mode),
        .duty_load  (duty_load)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        quad_pwm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .duty_load  (duty_load),
            .shd_duty   (shd_duty[i]),
            .cnt        (cnt),
            .act_period (act_period),
            .center     (act_mode.center),
            .down       (down),
            .level      (level[i])
        );
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign pwm_out[2*k]   = run_en & level[2*k];
        assign pwm_out[2*k+1] = run_en & (act_mode.paired ? ~level[2*k] : level[2*k+1]);
    end

    a_r10_off_low: assert property (@(posedge clk) disable iff (rst)
        $fell(run_en) |-> (pwm_out == '0));

    a_r8_pair_opposite: assert property (@(posedge clk) disable iff (rst)
        (run_en && act_mode.paired) |-> (pwm_out[1] != pwm_out[0]));

endmodule

// File: tb/quad_pwm_gen_bench.sv
module quad_pwm_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_pwm_gen u_quad_pwm_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive a write for the coming edge, without waiting
    task automatic drive(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 16'(d);
    endtask

    task automatic idle();
        wr_en = 1'b0;
    endtask

    // Called at a falling edge; returns one falling edge later
    task automatic wr(input int a, input int d);
        drive(a, d);
        @(negedge clk);
        idle();
    endtask

    // Stop, load shadows, start: returns at the cycle with count 0
    task automatic setup(input int p, input int m, input int d0, input int d1,
                         input int d2, input int d3);
        wr(6, 0);
        wr(0, d0);
        wr(1, d1);
        wr(2, d2);
        wr(3, d3);
        wr(4, p);
        wr(5, m);
        wr(6, 1);
    endtask

    function automatic logic e_edge(input int tt, input int p, input int d);
        if (d == 0) return 1'b0;
        if (d >= p) return 1'b1;
        return tt < d;
    endfunction

    // tt is the cycle index inside a center-aligned period of 2p cycles
    function automatic logic e_ctr(input int tt, input int p, input int d);
        if (d == 0) return 1'b0;
        if (d >= p) return 1'b1;
        if (tt < p) return tt >= p - d;
        return (tt - p) < d;
    endfunction

    task automatic test_reset();
        repeat (2) @(negedge clk);
        chk("R1 in reset", pwm_out, 4'b0000);
        rst = 1'b0;
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            chk("R1 after reset", pwm_out, 4'b0000);
        end
    endtask

    task automatic test_edge();
        setup(8, 0, 0, 3, 8, 12);
        for (int t = 0; t < 16; t++) begin
            chk("R2 R3 R5 R9 edge", pwm_out,
                {e_edge(t % 8, 8, 12), e_edge(t % 8, 8, 8),
                 e_edge(t % 8, 8, 3),  e_edge(t % 8, 8, 0)});
            @(negedge clk);
        end
    endtask

    task automatic test_center();
        setup(6, 1, 1, 4, 6, 0);
        for (int t = 0; t < 24; t++) begin
            chk("R4 R5 center", pwm_out,
                {e_ctr(t % 12, 6, 0), e_ctr(t % 12, 6, 6),
                 e_ctr(t % 12, 6, 4), e_ctr(t % 12, 6, 1)});
            @(negedge clk);
        end
    endtask

    task automatic test_shadow_edge();
        setup(8, 0, 2, 5, 1, 7);
        for (int t = 0; t < 18; t++) begin
            int p  = (t < 8) ? 8 : 5;
            int tt = (t < 8) ? t : (t - 8) % 5;
            int d0 = (t < 8) ? 2 : 6;
            chk("R6 reload at period end", pwm_out,
                {e_edge(tt, p, 7), e_edge(tt, p, 1), e_edge(tt, p, 5), e_edge(tt, p, d0)});
            if (t == 3)      drive(0, 6);
            else if (t == 4) drive(4, 5);
            else             idle();
            @(negedge clk);
        end
        idle();
    endtask

    task automatic test_midpoint(input bit dbl);
        setup(8, dbl ? 3 : 1, 2, 5, 3, 0);
        for (int t = 0; t < 32; t++) begin
            int  tt  = t % 16;
            bit  nu  = (t >= 16) || (dbl && tt >= 8);
            int  d0  = nu ? 6 : 2;
            int  d1  = nu ? 1 : 5;
            int  d2  = (t >= 16) ? 7 : 3;
            if (dbl)
                chk("R7 double update", pwm_out,
                    {1'b0, e_ctr(tt, 8, d2), e_ctr(tt, 8, d1), e_ctr(tt, 8, d0)});
            else
                chk("R6 single update", pwm_out,
                    {1'b0, e_ctr(tt, 8, d2), e_ctr(tt, 8, d1), e_ctr(tt, 8, d0)});
            if (t == 2)      drive(0, 6);
            else if (t == 3) drive(1, 1);
            else if (t == 7) drive(2, 7);
            else             idle();
            @(negedge clk);
        end
        idle();
    endtask

    task automatic test_paired();
        setup(5, 4, 2, 4, 3, 0);
        for (int t = 0; t < 10; t++) begin
            logic a = e_edge(t % 5, 5, 2);
            logic b = e_edge(t % 5, 5, 3);
            chk("R8 paired", pwm_out, {~b, b, ~a, a});
            @(negedge clk);
        end
    endtask

    task automatic test_disable();
        setup(8, 0, 3, 3, 3, 3);
        for (int t = 0; t < 5; t++) begin
            chk("R10 running", pwm_out, {4{e_edge(t, 8, 3)}});
            if (t == 4) drive(6, 0);
            @(negedge clk);
        end
        idle();
        for (int t = 0; t < 3; t++) begin
            chk("R10 stopped low", pwm_out, 4'b0000);
            @(negedge clk);
        end
        wr(0, 6);
        chk("R10 stopped after write", pwm_out, 4'b0000);
        wr(6, 1);
        for (int t = 0; t < 8; t++) begin
            chk("R10 restart", pwm_out,
                {e_edge(t, 8, 3), e_edge(t, 8, 3), e_edge(t, 8, 3), e_edge(t, 8, 6)});
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_edge();
        test_center();
        test_shadow_edge();
        test_midpoint(1'b0);
        test_midpoint(1'b1);
        test_paired();
        test_disable();
        finish_run();
    end

endmodule